// File: doc/BRIEF.md
# Group Interrupt Redistribution Calculator

This block runs when a hardware thread context has to hand back a group or crowd interrupt that it is currently holding. From the thread's virtual-processor block and index, and from the group and crowd levels carried in its notification status, it works out which group context owns the interrupt. It then asks an external table for that group context. From the reply, a queue base index and a priority-count exponent, it selects the event queue that matches the thread's pending priority. Finally it re-triggers that queue with redistribution marked, and tells the thread to drop its notification state.

A start pulse captures the thread's inputs. The block then steps through lookup, trigger and clear. Lookup and trigger are request/acknowledge handshakes that hold until the far side answers. A failed lookup ends the sequence with an error pulse and sends no trigger. The block does not hold the group-context table and does not route the queue trigger.

Top module: `grp_redist`

## Requirements
- R1: The notification status `nsr` is read as follows: bit 7 means an exception is signalled, bits 5:4 hold the crowd level and bits 3:0 hold the group level. A start pulse is acted on only when bit 7 is set and at least one level is nonzero. In every other case it is ignored: `busy` stays low and no lookup is requested.
- R2: The group index `lk_idx` equals `vp_idx` when the group level g is 0. For g > 0 it is `vp_idx` with its g low bits cleared, ORed with (1 << (g-1)) - 1.
- R3: A crowd level of 3 is treated as 4. With that effective crowd level c, the group block `lk_blk` equals `vp_blk` when c is 0. For c > 0 it is `vp_blk` with its c low bits cleared, ORed with (1 << (c-1)) - 1. `lk_crowd` is 1 exactly when the crowd level is nonzero.
- R4: The priority count is 1 << `lk_psize` when `cfg_grp_prio` is 1, and 1 << `cfg_prio_log2` when it is 0.
- R5: The trigger index `trg_idx` is `lk_qbase` plus (captured `pipr` modulo the priority count). `trg_blk` is `lk_qblk`.
- R6: Whenever `trg_req` is high, `trg_data` is 0 and `trg_redist` is 1.
- R7: A lookup acknowledged with `lk_err` = 1 raises `err` for exactly one cycle in the following cycle. It issues no trigger and returns the block to idle.
- R8: `lk_req` and `trg_req` stay high with stable block and index until their acknowledge is seen.
- R9: The cycle after a trigger is acknowledged, `clr_valid` is high for exactly one cycle, with `clr_pipr` equal to the `cppr` captured at start. The block is idle in the cycle after that.
- R10: After reset, `busy`, `lk_req`, `trg_req`, `clr_valid` and `err` are all 0.
- R11: A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to redistribute the thread's interrupt |
| nsr | input | 8 | Thread notification status |
| vp_blk | input | BLK_W | Thread virtual-processor block |
| vp_idx | input | IDX_W | Thread virtual-processor index |
| pipr | input | PRIO_W | Thread pending priority |
| cppr | input | PRIO_W | Thread current priority |
| cfg_grp_prio | input | 1 | Take the priority count from the group context |
| cfg_prio_log2 | input | 3 | Global priority-count exponent |
| busy | output | 1 | Sequence in progress |
| lk_req | output | 1 | Group-context lookup request |
| lk_crowd | output | 1 | Lookup targets a crowd context |
| lk_blk | output | BLK_W | Group/crowd block to look up |
| lk_idx | output | IDX_W | Group index to look up |
| lk_ack | input | 1 | Lookup answered |
| lk_err | input | 1 | Lookup failed |
| lk_psize | input | 3 | Group-context priority-count exponent |
| lk_qblk | input | BLK_W | Group-context queue block |
| lk_qbase | input | QIDX_W | Group-context queue base index |
| trg_req | output | 1 | Queue re-trigger request |
| trg_blk | output | BLK_W | Queue block |
| trg_idx | output | QIDX_W | Queue index |
| trg_data | output | DATA_W | Trigger data |
| trg_redist | output | 1 | Redistribution flag (no enqueue at destination) |
| trg_ack | input | 1 | Trigger accepted |
| clr_valid | output | 1 | Clear the thread's status and drop its line |
| clr_pipr | output | PRIO_W | New pending priority for the thread |
| err | output | 1 | Lookup failure pulse |

## Verification
The main sequence is run with five status patterns. They cover a group-only level, a crowd-only level of 1, the crowd level 3 that must act as 4, a mixed crowd and group case on an all-ones index, and the widest group level. Wrong fill or mask widths show up separately on the block and on the index. The vectors alternate the priority-count source, and each one places a deliberately different value in the unselected field, so a swapped select changes the queue offset. Directed cases cover statuses without the exception bit or without levels, a failed lookup, delayed acknowledges, and a start pulse arriving mid-sequence.

// File: rtl/grp_redist.sv
module grp_redist #(
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 16,
  parameter int QIDX_W = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        nsr,
  input  logic [BLK_W-1:0]  vp_blk,
  input  logic [IDX_W-1:0]  vp_idx,
  input  logic [PRIO_W-1:0] pipr,
  input  logic [PRIO_W-1:0] cppr,
  input  logic              cfg_grp_prio,
  input  logic [2:0]        cfg_prio_log2,
  output logic              busy,
  output logic              lk_req,
  output logic              lk_crowd,
  output logic [BLK_W-1:0]  lk_blk,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_ack,
  input  logic              lk_err,
  input  logic [2:0]        lk_psize,
  input  logic [BLK_W-1:0]  lk_qblk,
  input  logic [QIDX_W-1:0] lk_qbase,
  output logic              trg_req,
  output logic [BLK_W-1:0]  trg_blk,
  output logic [QIDX_W-1:0] trg_idx,
  output logic [DATA_W-1:0] trg_data,
  output logic              trg_redist,
  input  logic              trg_ack,
  output logic              clr_valid,
  output logic [PRIO_W-1:0] clr_pipr,
  output logic              err
);

  typedef enum logic [1:0] {S_IDLE, S_LOOKUP, S_TRIGGER, S_CLEAR} st_t;
  st_t st;

  logic              is_grp;
  logic [3:0]        glv;
  logic [2:0]        clv;
  logic [IDX_W-1:0]  gidx;
  logic [BLK_W-1:0]  gblk;
  logic [2:0]        lg;
  logic [PRIO_W-1:0] poff;

  assign glv    = nsr[3:0];
  assign clv    = (nsr[5:4] == 2'd3) ? 3'd4 : {1'b0, nsr[5:4]};
  assign is_grp = nsr[7] && (nsr[5:0] != 6'd0);

  assign gidx = (glv == 4'd0) ? vp_idx :
                ((vp_idx & ({IDX_W{1'b1}} << glv)) |
                 ((IDX_W'(1) << (glv - 4'd1)) - IDX_W'(1)));
  assign gblk = (clv == 3'd0) ? vp_blk :
                ((vp_blk & ({BLK_W{1'b1}} << clv)) |
                 ((BLK_W'(1) << (clv - 3'd1)) - BLK_W'(1)));

  assign lg   = cfg_grp_prio ? lk_psize : cfg_prio_log2;
  assign poff = clr_pipr_q_pend & ~({PRIO_W{1'b1}} << lg);

  logic [PRIO_W-1:0] clr_pipr_q_pend;
  logic [PRIO_W-1:0] cppr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      lk_crowd        <= 1'b0;
      lk_blk          <= '0;
      lk_idx          <= '0;
      trg_blk         <= '0;
      trg_idx         <= '0;
      clr_pipr_q_pend <= '0;
      cppr_q          <= '0;
      err             <= 1'b0;
    end else begin
      err <= 1'b0;
      case (st)
        S_IDLE: if (start && is_grp) begin
          st              <= S_LOOKUP;
          lk_crowd        <= (nsr[5:4] != 2'd0);
          lk_blk          <= gblk;
          lk_idx          <= gidx;
          clr_pipr_q_pend <= pipr;
          cppr_q          <= cppr;
        end
        S_LOOKUP: if (lk_ack) begin
          if (lk_err) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            trg_blk <= lk_qblk;
            trg_idx <= lk_qbase + QIDX_W'(poff);
            st      <= S_TRIGGER;
          end
        end
        S_TRIGGER: if (trg_ack) st <= S_CLEAR;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign lk_req     = (st == S_LOOKUP);
  assign trg_req    = (st == S_TRIGGER);
  assign clr_valid  = (st == S_CLEAR);
  assign clr_pipr   = cppr_q;
  assign trg_data   = '0;
  assign trg_redist = 1'b1;

endmodule

// File: rtl/grp_redist_chk.sv
module grp_redist_chk #(
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 16,
  parameter int QIDX_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        nsr,
  input logic              busy,
  input logic              lk_req,
  input logic [BLK_W-1:0]  lk_blk,
  input logic [IDX_W-1:0]  lk_idx,
  input logic              lk_ack,
  input logic              lk_err,
  input logic              trg_req,
  input logic [BLK_W-1:0]  trg_blk,
  input logic [QIDX_W-1:0] trg_idx,
  input logic [DATA_W-1:0] trg_data,
  input logic              trg_redist,
  input logic              trg_ack,
  input logic              clr_valid,
  input logic              err
);

  a_r1_ignore_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !(nsr[7] && nsr[5:0] != 6'd0)) |=> !busy);

  a_r6_retrigger_fields: assert property (@(posedge clk) disable iff (!rst_n)
    trg_req |-> (trg_redist && trg_data == '0));

  a_r7_err_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_ack && lk_err) |=> (!trg_req && err && !busy));

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  a_r8_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_ack) |=> (lk_req && $stable(lk_idx) && $stable(lk_blk)));

  a_r8_trigger_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_req && !trg_ack) |=> (trg_req && $stable(trg_idx) && $stable(trg_blk)));

  a_r9_clear_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_req && trg_ack) |=> clr_valid);

  a_r9_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> (!clr_valid && !busy));

  a_r9_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_req, trg_req, clr_valid}));

endmodule

bind grp_redist grp_redist_chk #(
  .BLK_W(BLK_W), .IDX_W(IDX_W), .QIDX_W(QIDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .nsr(nsr), .busy(busy),
  .lk_req(lk_req), .lk_blk(lk_blk), .lk_idx(lk_idx), .lk_ack(lk_ack),
  .lk_err(lk_err), .trg_req(trg_req), .trg_blk(trg_blk), .trg_idx(trg_idx),
  .trg_data(trg_data), .trg_redist(trg_redist), .trg_ack(trg_ack),
  .clr_valid(clr_valid), .err(err)
);

// File: tb/grp_redist_test.sv
module grp_redist_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  nsr = '0;
  logic [3:0]  vp_blk = '0;
  logic [15:0] vp_idx = '0;
  logic [7:0]  pipr = '0, cppr = '0;
  logic        cfg_grp_prio = 1'b0;
  logic [2:0]  cfg_prio_log2 = '0;
  logic        lk_ack = 1'b0, lk_err = 1'b0;
  logic [2:0]  lk_psize = '0;
  logic [3:0]  lk_qblk = '0;
  logic [15:0] lk_qbase = '0;
  logic        trg_ack = 1'b0;
  logic        busy, lk_req, lk_crowd, trg_req, trg_redist, clr_valid, err;
  logic [3:0]  lk_blk, trg_blk;
  logic [15:0] lk_idx, trg_idx;
  logic [31:0] trg_data;
  logic [7:0]  clr_pipr;

  grp_redist uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nsr(nsr), .vp_blk(vp_blk),
    .vp_idx(vp_idx), .pipr(pipr), .cppr(cppr), .cfg_grp_prio(cfg_grp_prio),
    .cfg_prio_log2(cfg_prio_log2), .busy(busy), .lk_req(lk_req),
    .lk_crowd(lk_crowd), .lk_blk(lk_blk), .lk_idx(lk_idx), .lk_ack(lk_ack),
    .lk_err(lk_err), .lk_psize(lk_psize), .lk_qblk(lk_qblk),
    .lk_qbase(lk_qbase), .trg_req(trg_req), .trg_blk(trg_blk),
    .trg_idx(trg_idx), .trg_data(trg_data), .trg_redist(trg_redist),
    .trg_ack(trg_ack), .clr_valid(clr_valid), .clr_pipr(clr_pipr), .err(err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  nsr;
    logic [3:0]  blk;
    logic [15:0] idx;
    logic [7:0]  pipr;
    logic [7:0]  cppr;
    logic        gen;
    logic [2:0]  glg;
    logic [2:0]  psz;
    logic [15:0] qbase;
    logic [3:0]  qblk;
    logic [3:0]  e_blk;
    logic [15:0] e_idx;
    logic        e_crowd;
    logic [15:0] e_tidx;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h83, 4'hA, 16'h1234, 8'h05, 8'h02, 1'b1, 3'd0, 3'd2, 16'h0100, 4'h1, 4'hA, 16'h1233, 1'b0, 16'h0101},
    '{8'h90, 4'hB, 16'h1234, 8'h06, 8'h03, 1'b0, 3'd3, 3'd0, 16'h0200, 4'h2, 4'hA, 16'h1234, 1'b1, 16'h0206},
    '{8'hB0, 4'h5, 16'hBEEF, 8'h07, 8'hFF, 1'b1, 3'd5, 3'd0, 16'h0300, 4'h3, 4'h7, 16'hBEEF, 1'b1, 16'h0300},
    '{8'hA1, 4'hE, 16'hFFFF, 8'h03, 8'h01, 1'b0, 3'd1, 3'd6, 16'h0010, 4'h4, 4'hD, 16'hFFFE, 1'b1, 16'h0011},
    '{8'h8F, 4'h3, 16'h9876, 8'h55, 8'h00, 1'b1, 3'd0, 3'd7, 16'h1000, 4'h5, 4'h3, 16'hBFFF, 1'b0, 16'h1055}
  };

  task automatic run_vec(input vec_t v, input bit fail_lk, input bit hold);
    nsr = v.nsr; vp_blk = v.blk; vp_idx = v.idx; pipr = v.pipr; cppr = v.cppr;
    cfg_grp_prio = v.gen; cfg_prio_log2 = v.glg;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(lk_req == 1'b1, "R1 lookup requested", 32'(lk_req), 1);
    chk(lk_idx == v.e_idx, "R2 group index", 32'(lk_idx), 32'(v.e_idx));
    chk(lk_blk == v.e_blk, "R3 crowd block", 32'(lk_blk), 32'(v.e_blk));
    chk(lk_crowd == v.e_crowd, "R3 crowd flag", 32'(lk_crowd), 32'(v.e_crowd));
    if (hold) begin
      nsr = 8'h81; vp_idx = 16'h0000; vp_blk = 4'h0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(lk_req == 1'b1, "R8 lookup held", 32'(lk_req), 1);
      chk(lk_idx == v.e_idx, "R11 start while busy ignored", 32'(lk_idx), 32'(v.e_idx));
    end
    lk_ack = 1'b1; lk_err = fail_lk; lk_psize = v.psz; lk_qblk = v.qblk;
    lk_qbase = v.qbase;
    @(negedge clk); lk_ack = 1'b0; lk_err = 1'b0;
    if (fail_lk) begin
      chk(err == 1'b1, "R7 error pulse", 32'(err), 1);
      chk(trg_req == 1'b0, "R7 no trigger", 32'(trg_req), 0);
      @(negedge clk);
      chk(err == 1'b0, "R7 error single", 32'(err), 0);
      chk(busy == 1'b0 && trg_req == 1'b0, "R7 back to idle", 32'(busy), 0);
      return;
    end
    chk(trg_req == 1'b1, "R5 trigger requested", 32'(trg_req), 1);
    chk(trg_idx == v.e_tidx, "R4 R5 queue index", 32'(trg_idx), 32'(v.e_tidx));
    chk(trg_blk == v.qblk, "R5 queue block", 32'(trg_blk), 32'(v.qblk));
    chk(trg_data == 32'd0 && trg_redist == 1'b1, "R6 trigger fields",
        {trg_data[30:0], trg_redist}, 32'd1);
    if (hold) begin
      @(negedge clk);
      chk(trg_req == 1'b1 && trg_idx == v.e_tidx, "R8 trigger held",
          32'(trg_idx), 32'(v.e_tidx));
    end
    trg_ack = 1'b1;
    @(negedge clk); trg_ack = 1'b0;
    chk(clr_valid == 1'b1, "R9 clear issued", 32'(clr_valid), 1);
    chk(clr_pipr == v.cppr, "R9 clear priority", 32'(clr_pipr), 32'(v.cppr));
    @(negedge clk);
    chk(clr_valid == 1'b0 && busy == 1'b0, "R9 clear single then idle",
        {clr_valid, busy}, 0);
  endtask

  task automatic ignored(input logic [7:0] s, input string tag);
    nsr = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0 && lk_req == 1'b0, tag, {busy, lk_req}, 0);
    @(negedge clk);
    chk(busy == 1'b0 && lk_req == 1'b0, tag, {busy, lk_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, lk_req, trg_req, clr_valid, err} == 5'd0, "R10 reset state",
        {busy, lk_req, trg_req, clr_valid, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, lk_req, trg_req, clr_valid, err} == 5'd0, "R10 after release",
        {busy, lk_req, trg_req, clr_valid, err}, 0);

    for (int i = 0; i < 5; i++) run_vec(VEC[i], 1'b0, 1'b0);

    ignored(8'h80, "R1 exception without levels ignored");
    ignored(8'h03, "R1 levels without exception ignored");
    ignored(8'h00, "R1 empty status ignored");

    run_vec(VEC[0], 1'b1, 1'b0);
    run_vec(VEC[3], 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule